// File: doc/BRIEF.md
# Auxiliary Packet Filter and Inserter

This block sits on the auxiliary packet path between a video receiver and a video transmitter. Packets arrive as a framed stream with start-of-packet, end-of-packet, valid and ready. The first beat of every packet carries the packet type in its low byte. Three types are discarded whole: audio clock regeneration, audio sample and the high-dynamic-range InfoFrame. Every other packet passes through with no change to its data or framing.

A single-cycle request pulse on `ins_req` splices a fixed, locally built four-beat HDR InfoFrame into the output. The splice happens only between packets, so a passthrough packet and an inserted frame never interleave. The output is a registered stage that honours `tx_ready`. A beat on the output stays stable while it is stalled, and the downstream port never sees a partial packet.

The merge controller has three states. **ST_GAP** means the controller is between packets. It goes to ST_INJECT when a request is pending and the frame header is taken. It goes to ST_FWD when a passthrough start beat without an end is taken. It stays in ST_GAP when a single-beat packet or the last frame beat completes. **ST_FWD** means a passthrough packet is open, and it returns to ST_GAP when that packet's end beat is taken. **ST_INJECT** means the inserted frame is in progress, and it returns to ST_GAP when the fourth beat is taken.

Top module: `aux_pkt_steer`

## Requirements
- R1: After reset, `tx_valid` is 0 and `rx_ready` is 1 while no input is offered.
- R2: The whole packet is removed when the low byte of its start beat is 0x01 (clock regeneration), 0x02 (audio sample) or 0x87 (HDR InfoFrame). No received HDR InfoFrame reaches the output.
- R3: A packet of any other type appears on the output in order, with every beat's data, `sop` and `eop` unchanged.
- R4: The keep or discard verdict taken on the start beat applies to every beat up to and including the end beat. The low byte of a continuation beat has no effect on the verdict.
- R5: The beats of a discarded packet are accepted on every cycle that they are offered, whatever the state of `tx_ready`.
- R6: While `tx_valid` is 1 and `tx_ready` is 0, the next cycle keeps `tx_valid`, `tx_data`, `tx_sop` and `tx_eop` unchanged.
- R7: Each served request emits exactly four beats:
  - beat 0 has every byte equal to 0x87 and `sop` set;
  - beat k (k = 1, 2, 3) has every byte equal to 0xC0 | k;
  - beat 3 carries `eop`.
- R8: A request that arrives during a passthrough packet waits until that packet's end beat has been output. Packets and frames never interleave on the output.
- R9: At a packet boundary with a request pending, the inserted frame is sent before the next passthrough packet, and that packet is stalled until the frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Input beat valid |
| rx_sop | input | 1 | Input start of packet |
| rx_eop | input | 1 | Input end of packet |
| rx_data | input | DATA_W | Input beat; the low byte of the start beat is the type |
| rx_ready | output | 1 | Input beat accepted when high with rx_valid |
| ins_req | input | 1 | Single-cycle request to insert one InfoFrame |
| tx_valid | output | 1 | Output beat valid |
| tx_sop | output | 1 | Output start of packet |
| tx_eop | output | 1 | Output end of packet |
| tx_data | output | DATA_W | Output beat |
| tx_ready | input | 1 | Downstream ready |

## Verification
The assertions check the following on every cycle:
- the stall-hold rule;
- output framing, meaning no start beat inside an open packet and no body beat outside one;
- the absence of audio type codes and received HDR InfoFrames on the output;
- the stalling of each source while the other source owns the output.

Only the bench's scenarios can show the following:
- that passing packets arrive whole and in order with their data intact;
- that discarded packets are consumed one beat per cycle even when the output is blocked;
- the exact contents of the inserted frame;
- the ordering of a deferred insertion relative to the packets around it.

// File: rtl/aux_steer_pkg.sv
package aux_steer_pkg;

    typedef enum logic [1:0] {
        ST_GAP,
        ST_FWD,
        ST_INJECT
    } merge_state_e;

    localparam logic [7:0] TYPE_CLK_REGEN = 8'h01;
    localparam logic [7:0] TYPE_AUD_SAMPLE = 8'h02;
    localparam logic [7:0] TYPE_HDR_FRAME = 8'h87;
    localparam logic [7:0] PAYLOAD_BASE = 8'hC0;
    localparam int FRAME_BEATS = 4;

    function automatic logic is_blocked(input logic [7:0] code);
        return (code == TYPE_CLK_REGEN) || (code == TYPE_AUD_SAMPLE) ||
               (code == TYPE_HDR_FRAME);
    endfunction

endpackage

// File: rtl/aux_type_filter.sv
module aux_type_filter
    import aux_steer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              fw_valid,
    output logic              fw_sop,
    output logic              fw_eop,
    output logic [DATA_W-1:0] fw_data,
    input  logic              fw_ready
);

    logic drop_hold;
    logic drop_now;

    // Verdict comes from the start beat; later beats reuse the latched one
    assign drop_now = in_sop ? is_blocked(in_data[7:0]) : drop_hold;

    assign fw_valid = in_valid & ~drop_now;
    assign fw_sop   = in_sop;
    assign fw_eop   = in_eop;
    assign fw_data  = in_data;
    assign in_ready = drop_now | fw_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drop_hold <= 1'b0;
        end else if (in_valid && in_ready) begin
            if (in_eop) begin
                drop_hold <= 1'b0;
            end else if (in_sop) begin
                drop_hold <= drop_now;
            end
        end
    end

    AST_DROP_BEAT_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_sop && !in_eop && is_blocked(in_data[7:0]))
        |=> (!in_valid || in_sop || !fw_valid)); // R4

endmodule

// File: rtl/aux_frame_gen.sv
module aux_frame_gen
    import aux_steer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic              g_sop,
    output logic              g_eop,
    output logic [DATA_W-1:0] g_data
);

    localparam int IDX_W = $clog2(FRAME_BEATS);
    localparam int LANES = DATA_W / 8;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BEATS - 1);

    logic [IDX_W-1:0] idx;
    logic [7:0]       lane_byte;

    always_comb begin
        if (idx == '0) begin
            lane_byte = TYPE_HDR_FRAME;
        end else begin
            lane_byte = PAYLOAD_BASE | 8'(idx);
        end
    end

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        assign g_data[ln*8 +: 8] = lane_byte;
    end

    assign g_sop = (idx == '0);
    assign g_eop = (idx == LAST_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (adv) begin
            idx <= g_eop ? '0 : idx + 1'b1;
        end
    end

endmodule

// File: rtl/aux_merge_fsm.sv
module aux_merge_fsm
    import aux_steer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fw_valid,
    input  logic              fw_sop,
    input  logic              fw_eop,
    input  logic [DATA_W-1:0] fw_data,
    output logic              fw_ready,
    input  logic              g_sop,
    input  logic              g_eop,
    input  logic [DATA_W-1:0] g_data,
    output logic              g_adv,
    input  logic              ins_req,
    output logic              out_valid,
    output logic              out_sop,
    output logic              out_eop,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ready
);

    merge_state_e state, state_nxt;
    logic pend;
    logic load_en;
    logic sel_gen;
    logic take;

    assign load_en = ~out_valid | out_ready;

    always_comb begin
        unique case (state)
            ST_GAP:    sel_gen = pend;
            ST_FWD:    sel_gen = 1'b0;
            ST_INJECT: sel_gen = 1'b1;
            default:   sel_gen = 1'b0;
        endcase
    end

    assign take     = load_en & (sel_gen | fw_valid);
    assign fw_ready = load_en & ~sel_gen;
    assign g_adv    = take & sel_gen;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_GAP: begin
                if (take) begin
                    if (sel_gen) begin
                        state_nxt = g_eop ? ST_GAP : ST_INJECT;
                    end else if (fw_sop && !fw_eop) begin
                        state_nxt = ST_FWD;
                    end
                end
            end
            ST_FWD: begin
                if (take && fw_eop) state_nxt = ST_GAP;
            end
            ST_INJECT: begin
                if (take && g_eop) state_nxt = ST_GAP;
            end
            default: state_nxt = ST_GAP;
        endcase
    end

    // State register and pending-request flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_GAP;
            pend  <= 1'b0;
        end else begin
            state <= state_nxt;
            pend  <= ins_req | (pend & ~(g_adv & g_sop));
        end
    end

    // Output register stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
            out_data  <= '0;
        end else if (take) begin
            out_valid <= 1'b1;
            out_sop   <= sel_gen ? g_sop  : fw_sop;
            out_eop   <= sel_gen ? g_eop  : fw_eop;
            out_data  <= sel_gen ? g_data : fw_data;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    AST_INJECT_STALLS_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INJECT) |-> !fw_ready); // R9
    AST_FWD_STALLS_GEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FWD) |-> !g_adv); // R8

endmodule

// File: rtl/aux_pkt_steer.sv
module aux_pkt_steer
    import aux_steer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              rx_sop,
    input  logic              rx_eop,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    input  logic              ins_req,
    output logic              tx_valid,
    output logic              tx_sop,
    output logic              tx_eop,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_ready
);

    localparam int LANES = DATA_W / 8;

    logic              fw_valid, fw_sop, fw_eop, fw_ready;
    logic [DATA_W-1:0] fw_data;
    logic              g_sop, g_eop, g_adv;
    logic [DATA_W-1:0] g_data;

    aux_type_filter #(.DATA_W(DATA_W)) filt_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(rx_valid), .in_sop(rx_sop), .in_eop(rx_eop), .in_data(rx_data),
        .in_ready(rx_ready),
        .fw_valid(fw_valid), .fw_sop(fw_sop), .fw_eop(fw_eop), .fw_data(fw_data),
        .fw_ready(fw_ready)
    );

    aux_frame_gen #(.DATA_W(DATA_W)) gen_i (
        .clk(clk), .rst_n(rst_n), .adv(g_adv),
        .g_sop(g_sop), .g_eop(g_eop), .g_data(g_data)
    );

    aux_merge_fsm #(.DATA_W(DATA_W)) merge_i (
        .clk(clk), .rst_n(rst_n),
        .fw_valid(fw_valid), .fw_sop(fw_sop), .fw_eop(fw_eop), .fw_data(fw_data),
        .fw_ready(fw_ready),
        .g_sop(g_sop), .g_eop(g_eop), .g_data(g_data), .g_adv(g_adv),
        .ins_req(ins_req),
        .out_valid(tx_valid), .out_sop(tx_sop), .out_eop(tx_eop), .out_data(tx_data),
        .out_ready(tx_ready)
    );

    // Output-side framing tracker for the checks below
    logic tx_open;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_open <= 1'b0;
        end else if (tx_valid && tx_ready) begin
            tx_open <= !tx_eop;
        end
    end

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) &&
                                     $stable(tx_sop) && $stable(tx_eop))); // R6
    AST_SOP_AT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_sop) |-> !tx_open); // R8
    AST_BODY_IN_PKT: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_sop) |-> tx_open); // R8
    AST_NO_AUDIO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_sop) |-> (tx_data[7:0] != TYPE_CLK_REGEN &&
                                  tx_data[7:0] != TYPE_AUD_SAMPLE)); // R2
    AST_HDR_ONLY_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_sop && tx_data[7:0] == TYPE_HDR_FRAME)
        |-> (tx_data == {LANES{TYPE_HDR_FRAME}})); // R2

endmodule

// File: tb/aux_pkt_steer_tb_top.sv
module aux_pkt_steer_tb_top;

    localparam int DW = 32;
    localparam int NVEC = 10;
    // {type, length, ready mode}: mode 0 always, 1 alternate, 2 one in four, 3 never
    localparam logic [15:0] VEC [NVEC] = '{
        {8'h84, 4'd3, 4'd1}, {8'h02, 4'd4, 4'd3}, {8'h01, 4'd2, 4'd3},
        {8'h87, 4'd5, 4'd3}, {8'h82, 4'd1, 4'd2}, {8'h00, 4'd3, 4'd0},
        {8'h02, 4'd1, 4'd3}, {8'h03, 4'd4, 4'd2}, {8'h07, 4'd2, 4'd1},
        {8'h81, 4'd3, 4'd0}
    };

    logic clk = 0;
    logic rst_n = 0;
    logic rx_valid = 0, rx_sop = 0, rx_eop = 0, ins_req = 0, tx_ready = 0;
    logic [DW-1:0] rx_data = '0;
    logic rx_ready, tx_valid, tx_sop, tx_eop;
    logic [DW-1:0] tx_data;

    int n_checks = 0, n_errors = 0, cyc = 0, rdy_mode = 0;
    int rx_n = 0, exp_n = 0;
    logic [DW+1:0] rx_beat [64];
    logic [DW+1:0] exp_beat [64];
    logic prev_stall = 0;
    logic [DW+1:0] prev_word;

    always #2.5 clk = ~clk;

    aux_pkt_steer #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_data(rx_data),
        .rx_ready(rx_ready), .ins_req(ins_req),
        .tx_valid(tx_valid), .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_data(tx_data),
        .tx_ready(tx_ready)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1;
        case (rdy_mode)
            0: tx_ready = 1'b1;
            1: tx_ready = cyc[0];
            2: tx_ready = (cyc % 4 == 3);
            default: tx_ready = 1'b0;
        endcase
    end

    // Monitor and stall-hold check (R6)
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin
                n_checks++;
                if (!tx_valid || {tx_sop, tx_eop, tx_data} != prev_word) begin
                    n_errors++;
                    $display("FAIL R6 stall hold: got v=%0b %h exp v=1 %h",
                             tx_valid, {tx_sop, tx_eop, tx_data}, prev_word);
                end
            end
            prev_stall = tx_valid && !tx_ready;
            prev_word  = {tx_sop, tx_eop, tx_data};
            if (tx_valid && tx_ready && rx_n < 64) begin
                rx_beat[rx_n] = {tx_sop, tx_eop, tx_data};
                rx_n++;
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 20000) begin
            n_errors++;
            $display("FAIL watchdog: got cycle %0d exp below 20000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    function automatic logic [DW-1:0] beat_data(input int id, input logic [7:0] t, input int j);
        return {8'(id), 8'(j), 8'hA5, (j == 0) ? t : 8'(j)};
    endfunction

    function automatic logic drop_code(input logic [7:0] t);
        return t == 8'h01 || t == 8'h02 || t == 8'h87;
    endfunction

    task automatic expect_pkt(input int id, input logic [7:0] t, input int len);
        for (int j = 0; j < len; j++) begin
            exp_beat[exp_n] = {j == 0, j == len - 1, beat_data(id, t, j)};
            exp_n++;
        end
    endtask

    task automatic expect_frame();
        for (int k = 0; k < 4; k++) begin
            exp_beat[exp_n] = {k == 0, k == 3, (k == 0) ? {4{8'h87}} : {4{8'hC0 | 8'(k)}}};
            exp_n++;
        end
    endtask

    task automatic send_pkt(input int id, input logic [7:0] t, input int len,
                            input int req_at, output int cycles);
        cycles = 0;
        for (int j = 0; j < len; j++) begin
            @(posedge clk); #1;
            rx_valid = 1; rx_sop = (j == 0); rx_eop = (j == len - 1);
            rx_data = beat_data(id, t, j); ins_req = (j == req_at);
            @(negedge clk); cycles++;
            while (!rx_ready) begin
                @(posedge clk); #1; ins_req = 0;
                @(negedge clk); cycles++;
            end
        end
        @(posedge clk); #1;
        rx_valid = 0; rx_sop = 0; rx_eop = 0; ins_req = 0;
    endtask

    task automatic drain_and_clear();
        rdy_mode = 0;
        repeat (12) @(posedge clk);
        @(negedge clk);
        rx_n = 0; exp_n = 0;
    endtask

    task automatic compare(input string tag);
        n_checks++;
        if (rx_n != exp_n) begin
            n_errors++;
            $display("FAIL %s beat count: got %0d exp %0d", tag, rx_n, exp_n);
        end
        for (int i = 0; i < exp_n && i < rx_n; i++) begin
            n_checks++;
            if (rx_beat[i] !== exp_beat[i]) begin
                n_errors++;
                $display("FAIL %s beat %0d: got %h exp %h", tag, i, rx_beat[i], exp_beat[i]);
            end
        end
    endtask

    initial begin
        int c;
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        n_checks++;   // R1
        if (tx_valid !== 1'b0 || rx_ready !== 1'b1) begin
            n_errors++;
            $display("FAIL R1 reset state: got valid=%0b ready=%0b exp valid=0 ready=1",
                     tx_valid, rx_ready);
        end
        drain_and_clear();

        // Table walk: R2 discards, R3 and R4 passthrough (continuation low bytes 0x01/0x02)
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] t;
            int len;
            t = VEC[v][15:8];
            len = int'(VEC[v][7:4]);
            if (!drop_code(t)) expect_pkt(v, t, len);
            rdy_mode = int'(VEC[v][3:0]);
            send_pkt(v, t, len, -1, c);
            if (drop_code(t)) begin
                n_checks++;   // R5
                if (c != len) begin
                    n_errors++;
                    $display("FAIL R5 discard cycles: got %0d exp %0d", c, len);
                end
            end
            rdy_mode = 0;
            repeat (12) @(posedge clk);
            @(negedge clk);
            compare(drop_code(t) ? "R2 discard" : "R3 R4 passthrough");
            rx_n = 0; exp_n = 0;
        end

        // R7: lone request under heavy backpressure
        rdy_mode = 2;
        @(posedge clk); #1 ins_req = 1;
        @(posedge clk); #1 ins_req = 0;
        expect_frame();
        repeat (30) @(posedge clk);
        @(negedge clk);
        compare("R7 frame");
        drain_and_clear();

        // R8 and R9: request mid-packet, next packet queued right behind
        rdy_mode = 1;
        expect_pkt(20, 8'h84, 4);
        expect_frame();
        expect_pkt(21, 8'h05, 2);
        send_pkt(20, 8'h84, 4, 1, c);
        send_pkt(21, 8'h05, 2, -1, c);
        repeat (20) @(posedge clk);
        @(negedge clk);
        compare("R8 R9 ordering");
        drain_and_clear();

        // R2 with R9: dropped HDR packet while a frame request is outstanding
        rdy_mode = 0;
        expect_frame();
        send_pkt(30, 8'h87, 3, 0, c);
        repeat (12) @(posedge clk);
        @(negedge clk);
        compare("R2 R9 local frame only");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule